// File: doc/BRIEF.md
# Ring-Buffer Packet Address Generator

This block produces the word address at which a packet receiver stores incoming data in a shared word memory. Software sets up a start pointer and a control word. The control word holds a receive ring enable and a window size code, plus a transmit enable and size code that are stored and read back only. Once receive is enabled, a packet-start strobe copies the pointer into the live write address and the receiver becomes busy. Each accepted word-write strobe then steps the address by one.

With the ring disabled, all address bits count and roll over from the top of the space to zero. With the ring enabled, the bits above the window stay at the values loaded from the pointer, and only the low field counts, wrapping inside a window of 64 to 1024 words. Single-cycle interrupt pulses mark three events: the end of a packet, the low field reaching half the window, and the low field wrapping back to zero. In slave operation, a finished transmission turns receive on by itself, so the peer's reply is captured without software having to act.

Top module: `rxr_addr_gen`

## Requirements
- R1: After reset, the write address is 0, the receiver is idle, receive is disabled, the control read-back is 0 and all interrupt outputs are low.
- R2: The control word reads back as {2'b00, rx_ring[7], rx_code[6:4], tx_ring[3], tx_code[2:0]}. Bits 9:8 are ignored on write and always read 0. The pointer reads back as written.
- R3: When receive is enabled and the receiver is idle, a packet-start strobe loads the pointer into the write address and makes the receiver busy from the next cycle. A strobe that arrives while receive is disabled or the receiver is busy changes neither the address nor the busy state.
- R4: With rx_ring = 0, each word-write strobe while busy adds one to the full 11-bit address, and 2047 rolls over to 0.
- R5: With rx_ring = 1, a word-write strobe while busy increments only the low field, and the bits above it keep their values. The low field is [5:0] for code 0, [6:0] for code 1, [7:0] for code 2, [8:0] for code 3 and [9:0] for codes 4 to 7.
- R6: With rx_ring = 1, irq_half is high for exactly the one cycle in which the updated low field first equals half the window size.
- R7: With rx_ring = 1, irq_full is high for exactly the one cycle in which the low field has just wrapped from all ones to zero.
- R8: A pkt_end strobe while busy returns the receiver to idle and raises irq_pkt for exactly one cycle. Both changes appear in the same cycle.
- R9: A word-write strobe while the receiver is idle leaves the address unchanged.
- R10: With slave_mode = 1, a tx_done pulse sets receive enable. With slave_mode = 0, tx_done has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 10 | Control word write data |
| cfg_rdata | output | 10 | Control word read-back |
| ptr_we | input | 1 | Start pointer write strobe |
| ptr_wdata | input | 11 | Start pointer write data |
| ptr_rdata | output | 11 | Start pointer read-back |
| rxen_we | input | 1 | Receive enable write strobe |
| rxen_wdata | input | 1 | Receive enable value |
| slave_mode | input | 1 | Lets tx_done set receive enable |
| tx_done | input | 1 | Transmission finished pulse |
| rx_enable | output | 1 | Current receive enable |
| pkt_start | input | 1 | Packet start seen on the bus |
| word_wr | input | 1 | One word stored this cycle |
| pkt_end | input | 1 | Packet finished |
| wr_addr | output | 11 | Live write address (status) |
| rx_busy | output | 1 | Receiver busy with a packet |
| irq_pkt | output | 1 | Packet complete pulse |
| irq_half | output | 1 | Window midpoint pulse |
| irq_full | output | 1 | Window end pulse |

## Verification
The assertions assume that reset is held for at least one clock at start-up and that every strobe is sampled synchronously, one cycle per request. They also assume the pointer is written before the packet start it belongs to. The bench keeps to these assumptions. It drives every strobe a short time after the rising edge and holds it for exactly one cycle. It writes the pointer and the control word in cycles of their own, before the packet start. The frozen-bits check compares against the window that was in force in the cycle before, so a control write made between packets never trips it.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic {RX_IDLE = 1'b0, RX_BUSY = 1'b1} rx_state_e;

  typedef struct packed {
    logic       rx_ring;
    logic [2:0] rx_code;
    logic       tx_ring;
    logic [2:0] tx_code;
  } ring_cfg_t;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int AW    = 11,
  parameter int CFG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ptr_we,
  input  logic [AW-1:0]    ptr_wdata,
  input  logic             rxen_we,
  input  logic             rxen_wdata,
  input  logic             slave_mode,
  input  logic             tx_done,
  output ring_cfg_t        cfg,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [AW-1:0]    ptr,
  output logic             rx_en
);
  localparam int FW = $bits(ring_cfg_t);
  localparam int RW = CFG_W - FW;

  logic unused_rsvd;
  assign unused_rsvd = ^cfg_wdata[CFG_W-1:FW];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      ptr   <= '0;
      rx_en <= 1'b0;
    end else begin
      if (cfg_we) cfg <= ring_cfg_t'(cfg_wdata[FW-1:0]);
      if (ptr_we) ptr <= ptr_wdata;
      if (rxen_we)                    rx_en <= rxen_wdata;
      else if (slave_mode && tx_done) rx_en <= 1'b1;
    end
  end

  assign cfg_rdata = {{RW{1'b0}}, cfg};

  AST_SLAVE_ARM: assert property (@(posedge clk) disable iff (rst)
    (slave_mode && tx_done && !rxen_we) |=> rx_en); // R10
endmodule

// File: rtl/rxr_window.sv
module rxr_window #(
  parameter int AW      = 11,
  parameter int CODE_W  = 3,
  parameter int MIN_LOG = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [AW-1:0]     mask,
  output logic [AW-1:0]     half
);
  localparam int NCODE = 1 << CODE_W;

  logic [AW-1:0] mask_tab [NCODE];
  logic [AW-1:0] half_tab [NCODE];

  for (genvar i = 0; i < NCODE; i++) begin : g_code
    localparam int LG = (MIN_LOG + i > AW - 1) ? AW - 1 : MIN_LOG + i;
    assign mask_tab[i] = {{(AW-LG){1'b0}}, {LG{1'b1}}};
    assign half_tab[i] = {{(AW-LG){1'b0}}, 1'b1, {(LG-1){1'b0}}};
  end

  assign mask = mask_tab[code];
  assign half = half_tab[code];
endmodule

// File: rtl/rxr_seq.sv
module rxr_seq
  import rxr_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic [AW-1:0] ptr,
  input  logic          ring,
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] half,
  input  logic          pkt_start,
  input  logic          word_wr,
  input  logic          pkt_end,
  output logic [AW-1:0] addr,
  output logic          busy,
  output logic          ev_half,
  output logic          ev_full,
  output logic          ev_pkt
);
  rx_state_e     state;
  logic          start_ok, adv;
  logic [AW-1:0] inc, nxt;

  assign busy     = (state == RX_BUSY);
  assign start_ok = !busy && rx_en && pkt_start;
  assign adv      = busy && word_wr;
  assign inc      = addr + AW'(1);
  assign nxt      = ring ? ((addr & ~mask) | (inc & mask)) : inc;
  assign ev_half  = adv && ring && ((nxt & mask) == half);
  assign ev_full  = adv && ring && ((nxt & mask) == '0);
  assign ev_pkt   = busy && pkt_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      addr  <= '0;
    end else begin
      if (start_ok) begin
        addr  <= ptr;
        state <= RX_BUSY;
      end else begin
        if (adv)    addr  <= nxt;
        if (ev_pkt) state <= RX_IDLE;
      end
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> (busy && addr == $past(ptr))); // R3
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && !ring) |=> (addr == $past(addr) + AW'(1))); // R4
  AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (adv && ring) |=> ((addr & ~$past(mask)) == ($past(addr) & ~$past(mask)))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !pkt_start) |=> $stable(addr)); // R9
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq (
  input  logic clk,
  input  logic rst,
  input  logic ev_half,
  input  logic ev_full,
  input  logic ev_pkt,
  output logic irq_half,
  output logic irq_full,
  output logic irq_pkt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_half <= 1'b0;
      irq_full <= 1'b0;
      irq_pkt  <= 1'b0;
    end else begin
      irq_half <= ev_half;
      irq_full <= ev_full;
      irq_pkt  <= ev_pkt;
    end
  end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_half, irq_full})); // R6
  AST_FULL_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_full |=> !irq_full); // R7
endmodule

// File: rtl/rxr_addr_gen.sv
module rxr_addr_gen
  import rxr_pkg::*;
#(
  parameter int AW      = 11,
  parameter int CFG_W   = 10,
  parameter int MIN_LOG = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             ptr_we,
  input  logic [AW-1:0]    ptr_wdata,
  output logic [AW-1:0]    ptr_rdata,
  input  logic             rxen_we,
  input  logic             rxen_wdata,
  input  logic             slave_mode,
  input  logic             tx_done,
  output logic             rx_enable,
  input  logic             pkt_start,
  input  logic             word_wr,
  input  logic             pkt_end,
  output logic [AW-1:0]    wr_addr,
  output logic             rx_busy,
  output logic             irq_pkt,
  output logic             irq_half,
  output logic             irq_full
);
  ring_cfg_t     cfg;
  logic [AW-1:0] mask, half;
  logic          ev_half, ev_full, ev_pkt;

  rxr_regs #(.AW(AW), .CFG_W(CFG_W)) u_regs (
    .clk, .rst, .cfg_we, .cfg_wdata, .ptr_we, .ptr_wdata,
    .rxen_we, .rxen_wdata, .slave_mode, .tx_done,
    .cfg(cfg), .cfg_rdata(cfg_rdata), .ptr(ptr_rdata), .rx_en(rx_enable)
  );

  rxr_window #(.AW(AW), .CODE_W(3), .MIN_LOG(MIN_LOG)) u_window (
    .code(cfg.rx_code), .mask(mask), .half(half)
  );

  rxr_seq #(.AW(AW)) u_seq (
    .clk, .rst, .rx_en(rx_enable), .ptr(ptr_rdata), .ring(cfg.rx_ring),
    .mask(mask), .half(half), .pkt_start, .word_wr, .pkt_end,
    .addr(wr_addr), .busy(rx_busy),
    .ev_half(ev_half), .ev_full(ev_full), .ev_pkt(ev_pkt)
  );

  rxr_irq u_irq (
    .clk, .rst, .ev_half(ev_half), .ev_full(ev_full), .ev_pkt(ev_pkt),
    .irq_half(irq_half), .irq_full(irq_full), .irq_pkt(irq_pkt)
  );

  AST_PKT_IDLE: assert property (@(posedge clk) disable iff (rst)
    irq_pkt |-> !rx_busy); // R8
endmodule

// File: tb/rxr_addr_gen_bench.sv
module rxr_addr_gen_bench;
  logic clk = 0, rst = 1;
  logic cfg_we = 0, ptr_we = 0, rxen_we = 0, rxen_wdata = 0;
  logic slave_mode = 0, tx_done = 0, pkt_start = 0, word_wr = 0, pkt_end = 0;
  logic [9:0]  cfg_wdata = 0, cfg_rdata;
  logic [10:0] ptr_wdata = 0, ptr_rdata, wr_addr;
  logic rx_enable, rx_busy, irq_pkt, irq_half, irq_full;

  always #5 clk = ~clk;

  rxr_addr_gen u_rxr_addr_gen (.*);

  typedef struct {
    int          due;
    logic [10:0] addr;
    logic        busy, pkt, half, full;
    string       tag;
  } item_t;
  item_t q[$];

  int checks = 0, errors = 0, cyc = 0;
  logic [10:0] m_addr = 0, m_ptr = 0;
  logic        m_busy = 0, m_rxen = 0, m_ring = 0;
  logic [2:0]  m_code = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      chk(wr_addr == it.addr, it.tag, "wr_addr", wr_addr, it.addr);
      chk(rx_busy == it.busy, it.tag, "rx_busy", rx_busy, it.busy);
      chk(irq_half == it.half, "R6", "irq_half", irq_half, it.half);
      chk(irq_full == it.full, "R7", "irq_full", irq_full, it.full);
      chk(irq_pkt == it.pkt, "R8", "irq_pkt", irq_pkt, it.pkt);
    end
  end

  function automatic logic [10:0] bmask(input logic [2:0] c);
    return (c >= 3'd4) ? 11'h3FF : ((11'd64 << c) - 11'd1);
  endfunction

  task automatic clear_strobes();
    pkt_start = 0; word_wr = 0; pkt_end = 0; cfg_we = 0; ptr_we = 0;
    rxen_we = 0; tx_done = 0;
  endtask

  task automatic step(input logic s, input logic w, input logic e, input string tag);
    item_t it;
    logic [10:0] mk;
    @(posedge clk); #2;
    clear_strobes();
    pkt_start = s; word_wr = w; pkt_end = e;
    it.half = 0; it.full = 0; it.pkt = 0; it.tag = tag;
    if (!m_busy) begin
      if (s && m_rxen) begin m_addr = m_ptr; m_busy = 1; end
    end else begin
      if (w) begin
        if (m_ring) begin
          mk = bmask(m_code);
          m_addr = (m_addr & ~mk) | ((m_addr + 11'd1) & mk);
          it.half = ((m_addr & mk) == ((mk + 11'd1) >> 1));
          it.full = ((m_addr & mk) == 11'd0);
        end else m_addr = m_addr + 11'd1;
      end
      if (e) begin m_busy = 0; it.pkt = 1; end
    end
    it.due = cyc + 1; it.addr = m_addr; it.busy = m_busy;
    q.push_back(it);
  endtask

  task automatic wr_cfg(input logic [9:0] v);
    @(posedge clk); #2; clear_strobes(); cfg_we = 1; cfg_wdata = v;
    @(posedge clk); #2; clear_strobes();
    m_ring = v[7]; m_code = v[6:4];
  endtask

  task automatic wr_ptr(input logic [10:0] v);
    @(posedge clk); #2; clear_strobes(); ptr_we = 1; ptr_wdata = v;
    @(posedge clk); #2; clear_strobes();
    m_ptr = v;
  endtask

  task automatic wr_rxen(input logic v);
    @(posedge clk); #2; clear_strobes(); rxen_we = 1; rxen_wdata = v;
    @(posedge clk); #2; clear_strobes();
    m_rxen = v;
  endtask

  task automatic packet(input logic [10:0] p, input logic [9:0] c, input int n, input string tag);
    wr_cfg(c);
    wr_ptr(p);
    step(1, 0, 0, "R3");
    for (int i = 0; i < n; i++) step(0, 1, 0, tag);
    step(0, 0, 1, "R8");
    step(0, 0, 0, "R8");
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    chk(wr_addr == 0, "R1", "wr_addr", wr_addr, 0);
    chk(rx_busy == 0, "R1", "rx_busy", rx_busy, 0);
    chk(rx_enable == 0, "R1", "rx_enable", rx_enable, 0);
    chk(cfg_rdata == 0, "R1", "cfg_rdata", cfg_rdata, 0);
    chk({irq_pkt, irq_half, irq_full} == 0, "R1", "irqs", {irq_pkt, irq_half, irq_full}, 0);

    wr_cfg(10'h3FF); @(negedge clk);
    chk(cfg_rdata == 10'h0FF, "R2", "cfg_rdata", cfg_rdata, 10'h0FF);
    wr_cfg(10'h35A); @(negedge clk);
    chk(cfg_rdata == 10'h05A, "R2", "cfg_rdata", cfg_rdata, 10'h05A);
    wr_cfg(10'h000);
    wr_ptr(11'h7FE); @(negedge clk);
    chk(ptr_rdata == 11'h7FE, "R2", "ptr_rdata", ptr_rdata, 11'h7FE);

    // R3: start ignored with receive disabled
    step(1, 0, 0, "R3");
    step(0, 0, 0, "R3");
    wr_rxen(1);
    step(1, 0, 0, "R3");
    wr_ptr(11'h123);
    step(1, 0, 0, "R3");           // R3: ignored while busy
    for (int i = 0; i < 4; i++) step(0, 1, 0, "R4");  // R4: 7FE..002 via 0
    step(0, 0, 1, "R8");
    step(0, 0, 0, "R8");
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R9"); // R9: idle writes ignored

    packet(11'h53C, 10'h080, 70, "R5");     // code 0, 64 words
    packet(11'h07E, 10'h090, 130, "R5");    // code 1, 128 words
    packet(11'h1FA, 10'h0A8, 260, "R5");    // code 2, tx fields set too
    packet(11'h6F0, 10'h0B0, 520, "R5");    // code 3, 512 words
    packet(11'h7F0, 10'h0E0, 1030, "R5");   // code 6 acts as 1024
    packet(11'h7FD, 10'h000, 5, "R4");      // ring off rolls over

    // R10: tx_done without slave mode has no effect
    wr_rxen(0);
    @(posedge clk); #2; clear_strobes(); tx_done = 1;
    @(posedge clk); #2; clear_strobes();
    @(negedge clk);
    chk(rx_enable == 0, "R10", "rx_enable", rx_enable, 0);
    slave_mode = 1;
    @(posedge clk); #2; clear_strobes(); tx_done = 1;
    @(posedge clk); #2; clear_strobes();
    @(negedge clk);
    chk(rx_enable == 1, "R10", "rx_enable", rx_enable, 1);
    m_rxen = 1;
    step(1, 0, 0, "R10");
    step(0, 1, 1, "R10");
    step(0, 0, 0, "R10");
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R8", "queue drained", q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule